// File: doc/BRIEF.md
# Stereo serial audio demultiplexer

This block takes a three-wire serial audio stream and splits it for two single-channel DACs. The three wires are a bit clock, a frame-sync line and one shared data line. Frame sync high selects the left sample and frame sync low selects the right sample. The block runs entirely in the bit-clock domain. Each data bit is taken on a rising bit-clock edge. Frame sync only marks where a word starts and which channel it belongs to.

The block has two kinds of output. Two serial lines each carry the bits of one channel only, one bit clock later, and stay low during the other channel's half frame. Each channel also has a parallel holding register. A finished left word waits in a staging register until the right word of the same frame is also complete. A one-cycle latch strobe then goes to the DACs, and on the edge where that strobe falls both parallel outputs change together. A frame-sync transition that arrives before a whole word has been received raises a one-cycle framing error, and the partial word is dropped.

Top module: `stereo_ser_demux`

## Requirements
- R1: Words are WORD_W bits (default 16), most significant bit first. The first bit is sampled on the same rising edge at which the changed frame-sync level is first seen.
- R2: A word received while frame sync is 1 is presented on `left_word_o`. A word received while frame sync is 0 is presented on `right_word_o`.
- R3: `left_ser_o` equals the data bit sampled on the previous rising edge when frame sync was 1 at that edge, and 0 otherwise. `right_ser_o` does the same for frame sync 0. The two are never high together.
- R4: `latch_o` is high for exactly one cycle. It starts right after the edge that samples the last bit of a right word, and only if a complete left word was received earlier in the same frame.
- R5: Both parallel outputs are loaded on the rising edge at which `latch_o` is high, so they change in the same cycle. At every other edge they hold their values.
- R6: A frame-sync transition seen while a word is open with fewer than WORD_W bits received drives `frame_err_o` high for one cycle. The partial word produces no latch, and the parallel outputs keep their values.
- R7: When a half frame is longer than WORD_W bits, the extra bits are ignored and do not change the captured word.
- R8: While `rst_n_i` is low, all outputs are 0. After reset no word is captured, and both serial outputs stay low, until the first frame-sync transition is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst_n_i | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | Frame sync: 1 = left half, 0 = right half |
| sdata_i | input | 1 | Shared serial data, MSB first |
| left_ser_o | output | 1 | Left-only serial stream |
| right_ser_o | output | 1 | Right-only serial stream |
| latch_o | output | 1 | One-cycle DAC latch strobe |
| frame_err_o | output | 1 | One-cycle pulse on a short word |
| left_word_o | output | WORD_W | Parallel left sample |
| right_word_o | output | WORD_W | Parallel right sample |

## Verification
The assertions assume that frame sync and data change only between rising bit-clock edges. They also assume that every frame starts with a left half followed by a right half, although a half may be short or long. The stimulus drives both lines on the falling edge. It sends frames whose half-frame lengths are drawn between a few bits and a few bits more than WORD_W, and it deliberately shortens some halves on either side. A reference model in the bench derives the expected serial, strobe, error and word values from the requirements, one bit at a time.

// File: rtl/sad_pkg.sv
package sad_pkg;
   localparam int CH_RIGHT = 0;   // index of the right channel, frame sync low
   localparam int CH_LEFT  = 1;   // index of the left channel, frame sync high
   localparam int NUM_CH   = 2;
endpackage

// File: rtl/sad_frame_track.sv
// Tracks frame-sync transitions and counts the bits of the open word.
module sad_frame_track #(
   parameter int WORD_W = 16
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic fsync_i,
   output logic fs_edge_o,
   output logic take_bit_o,
   output logic word_done_o,
   output logic short_word_o,
   output logic active_o
);
   localparam int CW = $clog2(WORD_W + 1);
   localparam logic [CW-1:0] FULL = CW'(WORD_W);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic          fs_q;
   logic          armed_q;
   logic [CW-1:0] cnt_q;

   assign fs_edge_o    = fsync_i != fs_q;
   assign take_bit_o   = fs_edge_o || (armed_q && (cnt_q < FULL));
   assign word_done_o  = !fs_edge_o && armed_q && (cnt_q == LAST);
   assign short_word_o = fs_edge_o && armed_q && (cnt_q != FULL);
   assign active_o     = armed_q || fs_edge_o;

   always_ff @(posedge clk_i) begin
      fs_q <= fsync_i;   // reset also samples the level, so no false edge follows
      if (!rst_n_i) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (fs_edge_o) begin
         armed_q <= 1'b1;
         cnt_q   <= CW'(1);
      end else if (take_bit_o) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R7: the counter saturates at the word length, so extra bits are dropped
   a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cnt_q <= FULL);
endmodule

// File: rtl/sad_shift_word.sv
// MSB-first shift register; word_o already includes the bit being sampled.
module sad_shift_word #(
   parameter int WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              take_bit_i,
   input  logic              sdata_i,
   output logic [WORD_W-1:0] word_o
);
   logic [WORD_W-1:0] sh_q;

   assign word_o = {sh_q[WORD_W-2:0], sdata_i};

   always_ff @(posedge clk_i) begin
      if (!rst_n_i)        sh_q <= '0;
      else if (take_bit_i) sh_q <= word_o;
   end
endmodule

// File: rtl/sad_ser_steer.sv
// Routes the shared data line to one of two per-channel serial outputs.
module sad_ser_steer (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic active_i,
   input  logic fsync_i,
   input  logic sdata_i,
   output logic left_ser_o,
   output logic right_ser_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         left_ser_o  <= 1'b0;
         right_ser_o <= 1'b0;
      end else begin
         left_ser_o  <= active_i &&  fsync_i && sdata_i;
         right_ser_o <= active_i && !fsync_i && sdata_i;
      end
   end

   // R3: only one channel output may carry data in any cycle
   a_r3_ser_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(left_ser_o && right_ser_o));
endmodule

// File: rtl/stereo_ser_demux.sv
module stereo_ser_demux #(
   parameter int WORD_W = 16
) (
   input  logic              bclk_i,
   input  logic              rst_n_i,
   input  logic              fsync_i,
   input  logic              sdata_i,
   output logic              left_ser_o,
   output logic              right_ser_o,
   output logic              latch_o,
   output logic              frame_err_o,
   output logic [WORD_W-1:0] left_word_o,
   output logic [WORD_W-1:0] right_word_o
);
   import sad_pkg::*;

   generate
      if (WORD_W < 2 || WORD_W > 32) begin : g_bad_width
         $error("stereo_ser_demux: WORD_W must be in 2..32");
      end
   endgenerate

   logic              fs_edge, take_bit, word_done, short_word, active;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] stage_q [NUM_CH];
   logic              left_ok_q;

   sad_frame_track #(.WORD_W(WORD_W)) track_i (
      .clk_i(bclk_i), .rst_n_i(rst_n_i), .fsync_i(fsync_i),
      .fs_edge_o(fs_edge), .take_bit_o(take_bit), .word_done_o(word_done),
      .short_word_o(short_word), .active_o(active));

   sad_shift_word #(.WORD_W(WORD_W)) shift_i (
      .clk_i(bclk_i), .rst_n_i(rst_n_i), .take_bit_i(take_bit),
      .sdata_i(sdata_i), .word_o(word));

   sad_ser_steer steer_i (
      .clk_i(bclk_i), .rst_n_i(rst_n_i), .active_i(active),
      .fsync_i(fsync_i), .sdata_i(sdata_i),
      .left_ser_o(left_ser_o), .right_ser_o(right_ser_o));

   // one staging register per channel, loaded when that channel's word completes
   for (genvar c = 0; c < NUM_CH; c++) begin : g_stage
      always_ff @(posedge bclk_i) begin
         if (!rst_n_i)
            stage_q[c] <= '0;
         else if (word_done && (fsync_i == 1'(c)))
            stage_q[c] <= word;
      end
   end

   always_ff @(posedge bclk_i) begin
      if (!rst_n_i) begin
         left_ok_q    <= 1'b0;
         latch_o      <= 1'b0;
         frame_err_o  <= 1'b0;
         left_word_o  <= '0;
         right_word_o <= '0;
      end else begin
         frame_err_o <= short_word;
         latch_o     <= word_done && !fsync_i && left_ok_q;
         if (fs_edge && fsync_i)
            left_ok_q <= 1'b0;
         else if (word_done)
            left_ok_q <= fsync_i;
         if (latch_o) begin
            left_word_o  <= stage_q[CH_LEFT];
            right_word_o <= stage_q[CH_RIGHT];
         end
      end
   end

   // R4: the strobe never lasts longer than one bit clock
   a_r4_latch_single: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
      latch_o |=> !latch_o);
   // R5: the parallel outputs move only at the edge ending a strobe
   a_r5_outputs_hold: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
      (!$past(latch_o) && $past(rst_n_i)) |-> ($stable(left_word_o) && $stable(right_word_o)));
   // R6: a short word never comes with a strobe
   a_r6_no_latch_on_err: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
      frame_err_o |-> !latch_o);
endmodule

// File: tb/stereo_ser_demux_tb.sv
module stereo_ser_demux_tb_top;
   localparam int W = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, fsync, sdata;
   logic left_ser, right_ser, latch, ferr;
   logic [W-1:0] left_word, right_word;

   stereo_ser_demux #(.WORD_W(W)) dut_i (
      .bclk_i(clk), .rst_n_i(rst_n), .fsync_i(fsync), .sdata_i(sdata),
      .left_ser_o(left_ser), .right_ser_o(right_ser), .latch_o(latch),
      .frame_err_o(ferr), .left_word_o(left_word), .right_word_o(right_word));

   int checks = 0;
   int errs   = 0;

   // reference model state, derived from the requirements
   bit           m_fs = 1'b0, m_armed = 1'b0, m_lok = 1'b0;
   int           m_cnt = 0;
   logic [W-1:0] m_word = '0, m_stL = '0, m_stR = '0;
   bit           exp_ls = 0, exp_rs = 0, exp_latch = 0, exp_err = 0;
   logic [W-1:0] exp_L = '0, exp_R = '0;

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   endtask

   task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic drive_bit(bit fs, bit b);
      bit edge_b, done, nl;
      logic [W-1:0] nL, nR;
      @(negedge clk);
      chk("R3 R8 left serial",  left_ser,  exp_ls);
      chk("R3 R8 right serial", right_ser, exp_rs);
      chk("R4 latch strobe",    latch,     exp_latch);
      chk("R6 framing error",   ferr,      exp_err);
      chk("R5 R2 left word",    left_word, exp_L);
      chk("R5 R2 right word",   right_word, exp_R);
      nL = exp_L; nR = exp_R;
      if (exp_latch) begin nL = m_stL; nR = m_stR; end
      edge_b = (fs != m_fs); m_fs = fs; done = 0; nl = 0; exp_err = 0;
      if (edge_b) begin
         exp_err = m_armed && (m_cnt < W);
         m_armed = 1; m_cnt = 1; m_word = {m_word[W-2:0], b};
         if (fs) m_lok = 0;
      end else if (m_armed && m_cnt < W) begin
         m_cnt++; m_word = {m_word[W-2:0], b}; done = (m_cnt == W);
      end
      if (done) begin
         if (fs) begin m_stL = m_word; m_lok = 1; end
         else begin
            m_stR = m_word;
            if (m_lok) begin nl = 1; m_lok = 0; end
         end
      end
      exp_latch = nl; exp_L = nL; exp_R = nR;
      exp_ls = m_armed &&  fs && b;
      exp_rs = m_armed && !fs && b;
      fsync = fs; sdata = b;
   endtask

   task automatic send_half(bit fs, logic [W-1:0] w, int nbits);
      for (int i = 0; i < nbits; i++)
         drive_bit(fs, (i < W) ? w[W-1-i] : 1'($urandom % 2));
   endtask

   task automatic send_frame(logic [W-1:0] l, logic [W-1:0] r, int nl, int nr);
      send_half(1'b1, l, nl);
      send_half(1'b0, r, nr);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errs++;
      $display("FAIL watchdog R4: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; fsync = 1'b0; sdata = 1'b1;
      repeat (4) @(negedge clk) sdata = 1'($urandom % 2);
      // R8: reset state
      chk("R8 reset serial", {left_ser, right_ser}, 2'b00);
      chk("R8 reset strobe", {latch, ferr}, 2'b00);
      chk("R8 reset words", {left_word, right_word}, '0);
      rst_n = 1'b1;
      // R8: bits before the first frame-sync transition are ignored
      send_half(1'b0, 16'hFFFF, 6);
      // R1 R2: directed word with distinct MSB and LSB
      send_frame(16'h8001, 16'h7FFE, W, W);
      drive_bit(1'b0, 1'b0); drive_bit(1'b0, 1'b0);
      chk("R1 R2 left MSB first",  left_word,  16'h8001);
      chk("R1 R2 right MSB first", right_word, 16'h7FFE);
      // R7: long half frames
      send_frame(16'hA5C3, 16'h3C5A, W + 5, W + 3);
      drive_bit(1'b0, 1'b1); drive_bit(1'b0, 1'b1);
      chk("R7 long slot left",  left_word,  16'hA5C3);
      chk("R7 long slot right", right_word, 16'h3C5A);
      // R6: short left half, no update
      send_frame(16'h1234, 16'h5678, W - 3, W);
      drive_bit(1'b0, 1'b0); drive_bit(1'b0, 1'b0);
      chk("R6 short left discarded", {left_word, right_word}, {16'hA5C3, 16'h3C5A});
      // R6: short right half, then a normal frame
      send_frame(16'h1111, 16'h2222, W, W - 2);
      send_frame(16'hBEEF, 16'h0F0F, W, W);
      drive_bit(1'b0, 1'b0); drive_bit(1'b0, 1'b0);
      chk("R6 recovery left",  left_word,  16'hBEEF);
      chk("R6 recovery right", right_word, 16'h0F0F);
      // random frames with occasional short halves
      for (int f = 0; f < 80; f++) begin
         int nl = W + int'($urandom % 4);
         int nr = W + int'($urandom % 4);
         if ($urandom % 8 == 0) nl = 1 + int'($urandom % (W - 1));
         if ($urandom % 8 == 0) nr = 1 + int'($urandom % (W - 1));
         send_frame(W'($urandom), W'($urandom), nl, nr);
      end
      send_half(1'b1, 16'h0000, W);
      summary();
   end
endmodule